// File: doc/BRIEF.md
# Submission and Completion Ring Engine

This engine services one channel of a descriptor-driven copy unit. Software places 32-byte work entries in a submission ring in memory and advances a tail pointer. Whenever the tail is ahead of the engine's own head pointer and the completion ring has room, the engine reads the next entry word by word, decodes it, and copies the requested bytes from source to destination one 32-bit word at a time. All of this goes through a single memory port that has one request outstanding at a time.

After each entry the engine writes a 16-byte completion record into the completion ring. The record carries the new submission head and a valid flag paired with a status code. The engine then moves both of its ring pointers forward, wrapping at the programmed depth. If the entry asked for it, the engine also raises a one-cycle completion event for the interrupt logic. Software frees completion slots by moving its completion head pointer forward. Enable and pause gate the start of new entries, and a queue reset drops the current entry.

Top module: `ringEngine`

## Requirements
- R1: A new entry starts only when enable=1, pause=0, sqHead != sqTail and the wrapped successor of cqTail differs from cqHeadSw. The engine then reads the 8 entry words at sqBase + 32*sqHead + 4*k, with k running from 0 to 7.
- R2: Entry decode uses these fields. The opcode is word 0 bits 3:0 and the interrupt flag is word 0 bit 8. Word 3 holds the byte length. The source address is word 4 (low) and word 5 (high), and the destination address is word 6 (low) and word 7 (high). Words 1 and 2 are ignored. A copy entry with a non-zero length takes exactly 12 + 2*ceil(len/4) memory transactions.
- R3: Opcode 0x4 copies ceil(len/4) full 32-bit words. Word i is read from src+4i and then written to dst+4i. The word after the last one is left untouched.
- R4: The completion record is 4 words written at cqBase + 16*cqTail. Words 0 and 1 are zero. Word 2 bits 15:0 hold the new sqHead and bits 31:16 are zero. Word 3 bits 15:0 are zero, bit 16 is the valid flag (1), and bits 31:17 hold the status (0 = success).
- R5: Any opcode other than 0x4, including 0x1, completes with status 1. It makes no source read and no destination write, so the entry takes exactly 12 transactions.
- R6: A copy entry with length 0 completes with status 0 after exactly 12 transactions and leaves the destination untouched.
- R7: After each completion record, sqHead and cqTail each advance by one in the same cycle. A pointer equal to depthM1 wraps to 0. Both pointers are 0 after rstN.
- R8: cplEvent is high for exactly one cycle, in the cycle the pointers first show their advanced values. It rises only for entries whose interrupt flag is set.
- R9: When the next cqTail would equal cqHeadSw, the engine fetches nothing and leaves its pointers alone until software moves cqHeadSw.
- R10: Pause and enable act only between entries. An entry already under way finishes, and no further entry starts while pause=1 or enable=0.
- R11: A cycle with qReset=1 abandons the current entry. In the next cycle sqHead=0, cqTail=0, memReq=0, and no completion is produced for the abandoned entry.
- R12: Once raised, memReq stays high with memWe, memAddr and memWdata stable until the cycle in which memAck=1 completes the transfer. On a read, memRdata is taken in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| qReset | input | 1 | Synchronous queue reset, abandons entry and clears pointers |
| enable | input | 1 | Allows new entries to start |
| pause | input | 1 | Holds off new entries while high |
| sqBase | input | 64 | Byte address of submission ring |
| cqBase | input | 64 | Byte address of completion ring |
| depthM1 | input | PTR_W | Ring depth minus one (both rings) |
| sqTail | input | PTR_W | Software submission tail |
| cqHeadSw | input | PTR_W | Software completion head |
| memReq | output | 1 | Memory request valid |
| memWe | output | 1 | Request is a write |
| memAddr | output | 64 | Word-aligned byte address |
| memWdata | output | 32 | Write data |
| memAck | input | 1 | Request accepted and finished this cycle |
| memRdata | input | 32 | Read data, valid with memAck |
| sqHead | output | PTR_W | Engine submission head |
| cqTail | output | PTR_W | Engine completion tail |
| cplEvent | output | 1 | One-cycle completion event |

## Verification
The properties assume a few things about the inputs. sqBase, cqBase and depthM1 stay constant while entries are in flight. depthM1 is at least 1. Software never moves cqHeadSw past the last completion written. The stimulus programs the bases and the depth once before reset is released. It moves cqHeadSw only to the engine's current cqTail, and it keeps at most depth-1 entries outstanding. A reset is always applied together with zeroed software pointers, so the engine never sees a tail that runs ahead of a freshly cleared head.

// File: rtl/ringEnginePkg.sv
package ringEnginePkg;

  localparam int ADDR_W    = 64;
  localparam int DATA_W    = 32;
  localparam int SQE_LAST  = 7;   // last word index of a submission entry
  localparam int CQE_LAST  = 3;   // last word index of a completion entry
  localparam int SQE_SHIFT = 5;   // 32-byte entries
  localparam int CQE_SHIFT = 4;   // 16-byte entries

  localparam logic [3:0]  OP_COPY   = 4'h4;
  localparam logic [14:0] STAT_OK   = 15'd0;
  localparam logic [14:0] STAT_BADOP = 15'd1;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FETCH,
    ST_DECODE,
    ST_RD,
    ST_WR,
    ST_CPL,
    ST_COMMIT
  } engState_t;

  typedef enum logic [1:0] {
    SEL_SQ,
    SEL_SRC,
    SEL_DST,
    SEL_CQ
  } busSel_t;

  typedef struct packed {
    logic    clrAll;
    logic    startEntry;
    logic    capWord;
    logic    startCopy;
    logic    capData;
    logic    stepCopy;
    logic    startCpl;
    logic    stepCpl;
    logic    commit;
    busSel_t sel;
  } ctrlStrobe_t;

endpackage

// File: rtl/ringCtrl.sv
module ringCtrl
  import ringEnginePkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        qReset,
  input  logic        enable,
  input  logic        pause,
  input  logic        memAck,
  input  logic        workReady,
  input  logic        fetchLast,
  input  logic        opIsCopy,
  input  logic        lenZero,
  input  logic        copyLast,
  input  logic        cplLast,
  output ctrlStrobe_t stb,
  output logic        memReq,
  output logic        memWe
);

  engState_t state, stateNext;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  always_comb begin
    stb       = '0;
    stb.sel   = SEL_SQ;
    memReq    = 1'b0;
    memWe     = 1'b0;
    stateNext = state;
    if (qReset) begin
      stb.clrAll = 1'b1;
      stateNext  = ST_IDLE;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (enable && !pause && workReady) begin
            stb.startEntry = 1'b1;
            stateNext      = ST_FETCH;
          end
        end
        ST_FETCH: begin
          memReq  = 1'b1;
          stb.sel = SEL_SQ;
          if (memAck) begin
            stb.capWord = 1'b1;
            if (fetchLast) stateNext = ST_DECODE;
          end
        end
        ST_DECODE: begin
          if (!opIsCopy || lenZero) begin
            stb.startCpl = 1'b1;
            stateNext    = ST_CPL;
          end else begin
            stb.startCopy = 1'b1;
            stateNext     = ST_RD;
          end
        end
        ST_RD: begin
          memReq  = 1'b1;
          stb.sel = SEL_SRC;
          if (memAck) begin
            stb.capData = 1'b1;
            stateNext   = ST_WR;
          end
        end
        ST_WR: begin
          memReq  = 1'b1;
          memWe   = 1'b1;
          stb.sel = SEL_DST;
          if (memAck) begin
            stb.stepCopy = 1'b1;
            if (copyLast) begin
              stb.startCpl = 1'b1;
              stateNext    = ST_CPL;
            end else begin
              stateNext = ST_RD;
            end
          end
        end
        ST_CPL: begin
          memReq  = 1'b1;
          memWe   = 1'b1;
          stb.sel = SEL_CQ;
          if (memAck) begin
            stb.stepCpl = 1'b1;
            if (cplLast) stateNext = ST_COMMIT;
          end
        end
        ST_COMMIT: begin
          stb.commit = 1'b1;
          stateNext  = ST_IDLE;
        end
        default: stateNext = ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/ringDatapath.sv
module ringDatapath
  import ringEnginePkg::*;
#(
  parameter int PTR_W = 10
) (
  input  logic                clk,
  input  logic                rstN,
  input  ctrlStrobe_t         stb,
  input  logic [ADDR_W-1:0]   sqBase,
  input  logic [ADDR_W-1:0]   cqBase,
  input  logic [PTR_W-1:0]    depthM1,
  input  logic [PTR_W-1:0]    sqTail,
  input  logic [PTR_W-1:0]    cqHeadSw,
  input  logic [DATA_W-1:0]   memRdata,
  output logic [ADDR_W-1:0]   memAddr,
  output logic [DATA_W-1:0]   memWdata,
  output logic [PTR_W-1:0]    sqHead,
  output logic [PTR_W-1:0]    cqTail,
  output logic                cplEvent,
  output logic                workReady,
  output logic                fetchLast,
  output logic                opIsCopy,
  output logic                lenZero,
  output logic                copyLast,
  output logic                cplLast
);

  localparam int IDX_W = $clog2(SQE_LAST + 1);
  localparam int REM_W = DATA_W - 1;

  function automatic logic [PTR_W-1:0] wrapInc(input logic [PTR_W-1:0] p,
                                               input logic [PTR_W-1:0] lim);
    return (p == lim) ? '0 : p + 1'b1;
  endfunction

  logic [IDX_W-1:0]  wIdx;
  logic [3:0]        opcode;
  logic              ieFlag;
  logic [DATA_W-1:0] lenBytes;
  logic [ADDR_W-1:0] srcAddr;
  logic [ADDR_W-1:0] dstAddr;
  logic [DATA_W-1:0] dataReg;
  logic [REM_W-1:0]  remWords;
  logic [14:0]       status;

  logic [PTR_W-1:0]  sqHeadNext;
  logic [PTR_W-1:0]  cqTailNext;
  logic [ADDR_W-1:0] sqSlotAddr;
  logic [ADDR_W-1:0] cqSlotAddr;

  assign sqHeadNext = wrapInc(sqHead, depthM1);
  assign cqTailNext = wrapInc(cqTail, depthM1);
  assign workReady  = (sqHead != sqTail) && (cqTailNext != cqHeadSw);
  assign fetchLast  = (wIdx == IDX_W'(SQE_LAST));
  assign cplLast    = (wIdx == IDX_W'(CQE_LAST));
  assign opIsCopy   = (opcode == OP_COPY);
  assign lenZero    = (lenBytes == '0);
  assign copyLast   = (remWords == REM_W'(1));

  assign sqSlotAddr = sqBase + (ADDR_W'(sqHead) << SQE_SHIFT) + ADDR_W'({wIdx, 2'b00});
  assign cqSlotAddr = cqBase + (ADDR_W'(cqTail) << CQE_SHIFT) + ADDR_W'({wIdx[1:0], 2'b00});

  always_comb begin
    unique case (stb.sel)
      SEL_SQ:  memAddr = sqSlotAddr;
      SEL_SRC: memAddr = srcAddr;
      SEL_DST: memAddr = dstAddr;
      default: memAddr = cqSlotAddr;
    endcase
  end

  always_comb begin
    memWdata = '0;
    if (stb.sel == SEL_DST) begin
      memWdata = dataReg;
    end else if (stb.sel == SEL_CQ) begin
      unique case (wIdx[1:0])
        2'd2:    memWdata = DATA_W'(sqHeadNext);
        2'd3:    memWdata = {status, 1'b1, 16'h0000};
        default: memWdata = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wIdx     <= '0;
      opcode   <= '0;
      ieFlag   <= 1'b0;
      lenBytes <= '0;
      srcAddr  <= '0;
      dstAddr  <= '0;
      dataReg  <= '0;
      remWords <= '0;
      status   <= STAT_OK;
      sqHead   <= '0;
      cqTail   <= '0;
      cplEvent <= 1'b0;
    end else if (stb.clrAll) begin
      wIdx     <= '0;
      sqHead   <= '0;
      cqTail   <= '0;
      cplEvent <= 1'b0;
    end else begin
      cplEvent <= 1'b0;
      if (stb.startEntry || stb.startCpl) wIdx <= '0;
      if (stb.capWord || stb.stepCpl)     wIdx <= wIdx + 1'b1;
      if (stb.capWord) begin
        unique case (wIdx)
          3'd0: begin
            opcode <= memRdata[3:0];
            ieFlag <= memRdata[8];
          end
          3'd3:    lenBytes              <= memRdata;
          3'd4:    srcAddr[31:0]         <= memRdata;
          3'd5:    srcAddr[ADDR_W-1:32]  <= memRdata;
          3'd6:    dstAddr[31:0]         <= memRdata;
          3'd7:    dstAddr[ADDR_W-1:32]  <= memRdata;
          default: ;
        endcase
      end
      if (stb.startCpl)  status   <= opIsCopy ? STAT_OK : STAT_BADOP;
      if (stb.startCopy) remWords <= lenBytes[DATA_W-1:2] + REM_W'(|lenBytes[1:0]);
      if (stb.capData)   dataReg  <= memRdata;
      if (stb.stepCopy) begin
        srcAddr  <= srcAddr + ADDR_W'(4);
        dstAddr  <= dstAddr + ADDR_W'(4);
        remWords <= remWords - 1'b1;
      end
      if (stb.commit) begin
        sqHead   <= sqHeadNext;
        cqTail   <= cqTailNext;
        cplEvent <= ieFlag;
      end
    end
  end

endmodule

// File: rtl/ringEngine.sv
module ringEngine
  import ringEnginePkg::*;
#(
  parameter int PTR_W = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              qReset,
  input  logic              enable,
  input  logic              pause,
  input  logic [63:0]       sqBase,
  input  logic [63:0]       cqBase,
  input  logic [PTR_W-1:0]  depthM1,
  input  logic [PTR_W-1:0]  sqTail,
  input  logic [PTR_W-1:0]  cqHeadSw,
  output logic              memReq,
  output logic              memWe,
  output logic [63:0]       memAddr,
  output logic [31:0]       memWdata,
  input  logic              memAck,
  input  logic [31:0]       memRdata,
  output logic [PTR_W-1:0]  sqHead,
  output logic [PTR_W-1:0]  cqTail,
  output logic              cplEvent
);

  ctrlStrobe_t stb;
  logic workReady, fetchLast, opIsCopy, lenZero, copyLast, cplLast;

  ringCtrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .qReset    (qReset),
    .enable    (enable),
    .pause     (pause),
    .memAck    (memAck),
    .workReady (workReady),
    .fetchLast (fetchLast),
    .opIsCopy  (opIsCopy),
    .lenZero   (lenZero),
    .copyLast  (copyLast),
    .cplLast   (cplLast),
    .stb       (stb),
    .memReq    (memReq),
    .memWe     (memWe)
  );

  ringDatapath #(.PTR_W(PTR_W)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .stb       (stb),
    .sqBase    (sqBase),
    .cqBase    (cqBase),
    .depthM1   (depthM1),
    .sqTail    (sqTail),
    .cqHeadSw  (cqHeadSw),
    .memRdata  (memRdata),
    .memAddr   (memAddr),
    .memWdata  (memWdata),
    .sqHead    (sqHead),
    .cqTail    (cqTail),
    .cplEvent  (cplEvent),
    .workReady (workReady),
    .fetchLast (fetchLast),
    .opIsCopy  (opIsCopy),
    .lenZero   (lenZero),
    .copyLast  (copyLast),
    .cplLast   (cplLast)
  );

endmodule

// File: rtl/ringEngineChk.sv
module ringEngineChk #(
  parameter int PTR_W = 10
) (
  input logic             clk,
  input logic             rstN,
  input logic             qReset,
  input logic [PTR_W-1:0] depthM1,
  input logic [PTR_W-1:0] cqHeadSw,
  input logic             memReq,
  input logic             memAck,
  input logic             memWe,
  input logic [63:0]      memAddr,
  input logic [31:0]      memWdata,
  input logic [PTR_W-1:0] sqHead,
  input logic [PTR_W-1:0] cqTail,
  input logic             cplEvent
);

  function automatic logic [PTR_W-1:0] succ(input logic [PTR_W-1:0] p,
                                            input logic [PTR_W-1:0] lim);
    return (p == lim) ? '0 : p + 1'b1;
  endfunction

  // R12
  req_hold_chk: assert property (@(posedge clk) disable iff (!rstN || qReset)
    (memReq && !memAck) |=> (memReq && $stable(memWe) && $stable(memAddr) && $stable(memWdata)));

  // R7
  head_step_chk: assert property (@(posedge clk) disable iff (!rstN || qReset)
    (!$past(qReset) && (sqHead != $past(sqHead))) |-> (sqHead == succ($past(sqHead), depthM1)));

  // R8
  event_pulse_chk: assert property (@(posedge clk) disable iff (!rstN || qReset)
    cplEvent |=> !cplEvent);

  // R9
  cq_room_chk: assert property (@(posedge clk) disable iff (!rstN || qReset)
    (!$past(qReset) && (cqTail != $past(cqTail))) |-> (cqTail != cqHeadSw));

  // R11
  qreset_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    $past(qReset) |-> (sqHead == '0 && cqTail == '0 && !memReq));

endmodule

bind ringEngine ringEngineChk #(.PTR_W(PTR_W)) i_ringEngineChk (
  .clk      (clk),
  .rstN     (rstN),
  .qReset   (qReset),
  .depthM1  (depthM1),
  .cqHeadSw (cqHeadSw),
  .memReq   (memReq),
  .memAck   (memAck),
  .memWe    (memWe),
  .memAddr  (memAddr),
  .memWdata (memWdata),
  .sqHead   (sqHead),
  .cqTail   (cqTail),
  .cplEvent (cplEvent)
);

// File: tb/test_ringEngine.sv
`timescale 1ns/1ps
module test_ringEngine;

  localparam int PW = 10;
  localparam longint unsigned SQ_BASE  = 64'h0000_1000;
  localparam longint unsigned CQ_BASE  = 64'h0000_8000;
  localparam longint unsigned SRC_BASE = 64'h0002_0000;
  localparam longint unsigned DST_BASE = 64'h0004_0000;

  logic          clk = 1'b0;
  logic          rstN, qReset, enable, pause;
  logic [63:0]   sqBase, cqBase;
  logic [PW-1:0] depthM1, sqTail, cqHeadSw;
  logic          memReq, memWe, memAck;
  logic [63:0]   memAddr;
  logic [31:0]   memWdata, memRdata;
  logic [PW-1:0] sqHead, cqTail;
  logic          cplEvent;

  always #2.5 clk = ~clk;

  ringEngine #(.PTR_W(PW)) i_ringEngine (
    .clk(clk), .rstN(rstN), .qReset(qReset), .enable(enable), .pause(pause),
    .sqBase(sqBase), .cqBase(cqBase), .depthM1(depthM1), .sqTail(sqTail),
    .cqHeadSw(cqHeadSw), .memReq(memReq), .memWe(memWe), .memAddr(memAddr),
    .memWdata(memWdata), .memAck(memAck), .memRdata(memRdata),
    .sqHead(sqHead), .cqTail(cqTail), .cplEvent(cplEvent)
  );

  typedef struct {
    logic [PW-1:0]   newHead;
    logic [14:0]     status;
    logic            ie;
    longint unsigned src;
    longint unsigned dst;
    int              nw;
    int              txns;
    bit              moves;
  } exp_t;

  exp_t expQ[$];
  logic [31:0] mem [longint unsigned];
  int nCmp = 0;
  int nBad = 0;
  int txnCount = 0;
  int prevTxn = 0;
  logic [PW-1:0] prevTail = '0;
  logic [PW-1:0] swTail = '0;
  int entryNum = 0;
  bit inReset = 1'b0;
  bit done = 1'b0;

  task automatic chk(input string req, input string what,
                     input longint unsigned act, input longint unsigned expv);
    nCmp++;
    if (act != expv) begin
      nBad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
    end
  endtask

  function automatic logic [31:0] rdMem(input longint unsigned a);
    return mem.exists(a) ? mem[a] : 32'h0;
  endfunction

  function automatic logic [PW-1:0] nextPtr(input logic [PW-1:0] p);
    return (p == depthM1) ? '0 : p + 1'b1;
  endfunction

  // memory model: one request at a time, variable latency
  initial begin : memModel
    int lat;
    bit pending;
    longint unsigned pendAddr;
    lat = 0; pending = 0; pendAddr = 0;
    memAck = 1'b0;
    memRdata = '0;
    forever begin
      @(negedge clk);
      if (memAck) begin
        memAck = 1'b0;
      end else if (memReq) begin
        if (!pending) begin
          pending = 1'b1;
          pendAddr = memAddr;
        end
        if (lat > 0) begin
          lat--;
        end else begin
          chk("R12", "address held until ack", memAddr, pendAddr);
          if (memWe) mem[memAddr] = memWdata;
          else       memRdata = rdMem(memAddr);
          memAck = 1'b1;
          pending = 1'b0;
          txnCount++;
          lat = txnCount % 3;
        end
      end else begin
        pending = 1'b0;
      end
    end
  end

  // monitor: pops expected completions as cqTail advances
  initial begin : monitor
    exp_t e;
    longint unsigned slot;
    logic [31:0] w2, w3;
    forever begin
      @(negedge clk);
      if (rstN && !inReset && cqTail != prevTail) begin
        if (expQ.size() == 0) begin
          chk("R7", "unexpected completion tail", cqTail, prevTail);
        end else begin
          e = expQ.pop_front();
          slot = CQ_BASE + 64'(prevTail) * 16;
          w2 = rdMem(slot + 8);
          w3 = rdMem(slot + 12);
          chk("R4", "cq words 0,1", rdMem(slot) | rdMem(slot + 4), 0);
          chk("R4", "cq word2 head", w2, 32'(e.newHead));
          chk("R4", "cq word3 low/valid", {w3[16:0]}, 17'h10000);
          chk("R4", "cq status", w3[31:17], e.status);
          chk("R7", "sqHead advance", sqHead, e.newHead);
          chk("R7", "cqTail advance", cqTail, nextPtr(prevTail));
          chk("R8", "event matches flag", cplEvent, e.ie);
          if (e.moves) begin
            chk("R2", "transaction count", txnCount - prevTxn, e.txns);
            for (int i = 0; i < e.nw; i++)
              chk("R3", "copied word", rdMem(e.dst + 4 * i), rdMem(e.src + 4 * i));
            chk("R3", "word past end untouched", rdMem(e.dst + 4 * e.nw),
                32'hDEAD0000 | 32'(e.nw));
          end else if (e.status != 0) begin
            chk("R5", "bad opcode transactions", txnCount - prevTxn, e.txns);
            chk("R5", "bad opcode dst untouched", rdMem(e.dst), 32'hDEAD0000);
          end else begin
            chk("R6", "zero length transactions", txnCount - prevTxn, e.txns);
            chk("R6", "zero length dst untouched", rdMem(e.dst), 32'hDEAD0000);
          end
        end
        prevTail = cqTail;
        prevTxn = txnCount;
      end else if (rstN && !inReset && cplEvent) begin
        chk("R8", "event without completion", 1, 0);
      end
    end
  end

  task automatic submit(input logic [3:0] op, input logic ie, input int len);
    exp_t e;
    longint unsigned ea, src, dst;
    int nw;
    ea  = SQ_BASE + 64'(swTail) * 32;
    src = SRC_BASE + 64'(entryNum) * 256;
    dst = DST_BASE + 64'(entryNum) * 256;
    nw  = (len + 3) / 4;
    mem[ea]      = {23'd0, ie, 4'd0, op};
    mem[ea + 4]  = 32'h0000_5000;
    mem[ea + 8]  = 32'h0300_0000;
    mem[ea + 12] = 32'(len);
    mem[ea + 16] = src[31:0];
    mem[ea + 20] = src[63:32];
    mem[ea + 24] = dst[31:0];
    mem[ea + 28] = dst[63:32];
    for (int i = 0; i < nw; i++) mem[src + 4 * i] = 32'hA500_0000 | 32'(entryNum << 8) | 32'(i);
    for (int i = 0; i <= nw; i++) mem[dst + 4 * i] = 32'hDEAD0000 | 32'(i);
    e.newHead = nextPtr(swTail);
    e.status  = (op == 4'h4) ? 15'd0 : 15'd1;
    e.ie      = ie;
    e.src     = src;
    e.dst     = dst;
    e.nw      = nw;
    e.moves   = (op == 4'h4) && (len != 0);
    e.txns    = 12 + (e.moves ? 2 * nw : 0);
    expQ.push_back(e);
    swTail = e.newHead;
    entryNum++;
    sqTail = swTail;
  endtask

  task automatic waitDone();
    int t = 0;
    while (expQ.size() != 0 && t < 4000) begin
      @(negedge clk);
      t++;
    end
    chk("R1", "pending entries drained", expQ.size(), 0);
  endtask

  task automatic consume();
    @(negedge clk);
    cqHeadSw = cqTail;
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      nBad++;
      nCmp++;
      $display("FAIL watchdog: actual hung expected finished");
      summary();
      $finish;
    end
  end

  initial begin : mainFlow
    logic [PW-1:0] h;
    int t;
    rstN = 1'b0; qReset = 1'b0; enable = 1'b1; pause = 1'b0;
    sqBase = SQ_BASE; cqBase = CQ_BASE; depthM1 = 10'd3;
    sqTail = '0; cqHeadSw = '0;
    repeat (4) @(negedge clk);
    chk("R7", "reset sqHead", sqHead, 0);
    chk("R7", "reset cqTail", cqTail, 0);
    chk("R12", "reset memReq", memReq, 0);
    chk("R8", "reset cplEvent", cplEvent, 0);
    rstN = 1'b1;
    @(negedge clk);

    // plain copies, mixed lengths and flags (R2, R3, R4)
    submit(4'h4, 1'b1, 8);
    submit(4'h4, 1'b0, 6);
    submit(4'h4, 1'b1, 4);
    waitDone();
    consume();

    // unsupported opcodes and zero length, crossing the wrap (R5, R6, R7)
    submit(4'h1, 1'b1, 8);
    submit(4'h7, 1'b0, 16);
    submit(4'h4, 1'b1, 0);
    waitDone();
    consume();

    // completion ring full stall (R9)
    submit(4'h4, 1'b1, 12);
    submit(4'h4, 1'b0, 12);
    submit(4'h4, 1'b1, 12);
    waitDone();
    h = sqHead;
    submit(4'h4, 1'b1, 8);
    repeat (60) @(negedge clk);
    chk("R9", "stalled entry pending", expQ.size(), 1);
    chk("R9", "no fetch while full", memReq, 0);
    chk("R9", "head held while full", sqHead, h);
    consume();
    waitDone();
    consume();

    // pause while idle (R10)
    pause = 1'b1;
    h = sqHead;
    submit(4'h4, 1'b1, 8);
    repeat (40) @(negedge clk);
    chk("R10", "paused entry pending", expQ.size(), 1);
    chk("R10", "no request while paused", memReq, 0);
    chk("R10", "head held while paused", sqHead, h);
    pause = 1'b0;
    waitDone();
    consume();

    // pause during an entry: it finishes, the next waits (R10)
    submit(4'h4, 1'b1, 40);
    submit(4'h4, 1'b1, 4);
    t = 0;
    while (!memReq && t < 200) begin
      @(negedge clk);
      t++;
    end
    pause = 1'b1;
    repeat (300) @(negedge clk);
    chk("R10", "running entry finished", expQ.size(), 1);
    chk("R10", "second entry held", memReq, 0);
    pause = 1'b0;
    waitDone();
    consume();

    // enable low blocks start (R1)
    enable = 1'b0;
    submit(4'h4, 1'b0, 8);
    repeat (40) @(negedge clk);
    chk("R1", "disabled entry pending", expQ.size(), 1);
    chk("R1", "no request while disabled", memReq, 0);
    enable = 1'b1;
    waitDone();
    consume();

    // queue reset in the middle of a long copy (R11)
    submit(4'h4, 1'b1, 128);
    repeat (30) @(negedge clk);
    inReset = 1'b1;
    qReset = 1'b1;
    sqTail = '0;
    cqHeadSw = '0;
    swTail = '0;
    expQ.delete();
    @(negedge clk);
    qReset = 1'b0;
    chk("R11", "sqHead cleared", sqHead, 0);
    chk("R11", "cqTail cleared", cqTail, 0);
    chk("R11", "request dropped", memReq, 0);
    chk("R11", "no completion event", cplEvent, 0);
    prevTail = '0;
    prevTxn = txnCount;
    inReset = 1'b0;
    repeat (20) @(negedge clk);
    chk("R11", "abandoned entry not completed", cqTail, 0);
    submit(4'h4, 1'b1, 8);
    waitDone();
    consume();

    repeat (5) @(negedge clk);
    done = 1'b1;
    summary();
    $finish;
  end

endmodule